// File: doc/BRIEF.md
# Two-Pattern Scan Test Sequencer

This controller applies two-pattern delay tests to a mux-D scan chain of `CHAIN_LEN` cells. Each test loads a first vector serially with scan-enable high. It then fires a launch clock and a capture clock, and finally shifts the captured response out. Two launch styles are available, chosen for each pattern. In shift-launch mode the launch is one more shift with scan-enable still high, so the second vector is the first one moved by one cell. In functional-launch mode scan-enable is low for both the launch and the capture clocks, so the second vector is the circuit's own next state. A programmable number of quiet cycles can be placed before a functional launch, which gives a slow scan-enable net time to settle.

Pattern bits arrive on a valid/ready serial stream and are taken most significant bit first. The response of test i leaves on a valid-only serial stream while the first vector of test i+1 is being shifted in, so every shift does both jobs. The chain itself is outside the block. The block drives `scan_en`, a per-cycle chain clock enable `chain_ce` and the serial input `scan_in`, and it reads the chain's last cell on `scan_out`. All outputs are registered.

Top module: `scan_pair_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `scan_en`=1, `chain_ce`=0, `rsp_valid`=0, `done`=0 and `pat_ready`=1.
- R2: Pattern bits are taken on cycles where `pat_valid`&`pat_ready` is high, most significant bit first. Each accepted bit is applied as one chain shift (`chain_ce`=1, `scan_en`=1) in the next cycle, so bit j of the pattern word ends in chain cell j, where cell CHAIN_LEN-1 drives `scan_out`.
- R3: Shift-launch (`mode_los`=1 at the first bit of a pattern): CHAIN_LEN-1 bits are loaded, and the last bit is applied as the launch shift. The very next cycle is the single capture cycle (`chain_ce`=1, `scan_en`=0).
- R4: Functional launch (`mode_los`=0): all CHAIN_LEN bits are loaded, then exactly two consecutive cycles with `chain_ce`=1 and `scan_en`=0 (launch, capture) are issued.
- R5: In functional-launch mode exactly `idle_gap` cycles with `chain_ce`=0 and `scan_en`=0 separate the last load shift from the launch. Shift-launch mode has none. A quiet gap cycle is always followed by another gap cycle or by the launch.
- R6: Launch and capture fall in consecutive cycles in both modes, and no more than two functional clocks occur back to back.
- R7: The response of a non-final test is shifted out during the load of the next pattern. T tests therefore take exactly (T+1)·CHAIN_LEN shift cycles in total.
- R8: Each unload shift produces one `rsp_valid` pulse carrying the bit on `scan_out` before that shift, one cycle after the shift. Each test yields exactly CHAIN_LEN bits, taken from cell CHAIN_LEN-1 down to cell 0.
- R9: While a needed pattern bit is missing (`pat_valid`=0), the chain is not clocked and `scan_en` stays 1. Loaded data is unaffected by such stalls.
- R10: `done` rises in the same cycle as the final response bit of the last pattern and stays high, with the chain idle, until reset or until a new pattern bit is accepted. It is low before that point.
- R11: `mode_los` and `idle_gap` are sampled with the first bit of each pattern, so modes may change from pattern to pattern. `pat_last` set on any bit marks that pattern as the final one. After its capture, CHAIN_LEN shifts with `scan_in`=0 unload the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_los | input | 1 | 1 = shift launch, 0 = functional launch; sampled at first bit |
| idle_gap | input | GAP_W | Quiet cycles before a functional launch; sampled at first bit |
| pat_valid | input | 1 | Pattern bit valid |
| pat_data | input | 1 | Pattern bit |
| pat_last | input | 1 | Marks the final pattern |
| pat_ready | output | 1 | Pattern bit can be taken |
| scan_en | output | 1 | Chain scan-enable |
| chain_ce | output | 1 | Chain clock enable for this cycle |
| scan_in | output | 1 | Serial data into the chain |
| scan_out | input | 1 | Last chain cell |
| rsp_valid | output | 1 | Response bit valid |
| rsp_data | output | 1 | Response bit |
| done | output | 1 | Final response fully shifted out |

## Verification
A wrong shift count or a mode sampled at the wrong time corrupts the captured response. That shows up as a wrong response word at the port CHAIN_LEN shifts after the capture. A miscounted gap, a split launch/capture pair or a missing overlap changes the run of `scan_en`/`chain_ce` values. That is visible at the ports within the same test, as an extra or missing quiet cycle or as an extra CHAIN_LEN shifts. A bad final-pattern flag either never raises `done` or raises it before all response bits have left.

// File: rtl/sps_pkg.sv
package sps_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_GAP,
    ST_LAUNCH,
    ST_CAPT,
    ST_UNLOAD
  } sps_state_e;

  // Chain action requested for the following cycle
  typedef struct packed {
    logic ce;     // clock the chain
    logic se;     // scan-enable level
    logic sin;    // serial bit into the chain
    logic unl;    // this shift unloads a response bit
    logic fin;    // this shift moves out the final response bit
    logic start;  // first bit of a run accepted
  } sps_issue_t;
endpackage

// File: rtl/sps_counter.sv
module sps_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (inc)   q <= q + 1'b1;
  end
endmodule

// File: rtl/sps_ctrl.sv
module sps_ctrl
  import sps_pkg::*;
#(
  parameter int CHAIN_LEN = 32,
  parameter int GAP_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_los,
  input  logic [GAP_W-1:0] idle_gap,
  input  logic             pat_valid,
  input  logic             pat_data,
  input  logic             pat_last,
  output logic             pat_ready,
  output sps_issue_t       iss
);
  localparam int CW = $clog2(CHAIN_LEN + 1);
  localparam logic [CW-1:0] END_FULL  = CW'(CHAIN_LEN - 1);
  localparam logic [CW-1:0] END_SHORT = CW'(CHAIN_LEN - 2);

  sps_state_e st_q, st_n;
  logic             mode_q, last_q, unl_q;
  logic [GAP_W-1:0] gap_q;
  logic [CW-1:0]    cnt;
  logic [GAP_W-1:0] gcnt;
  logic cnt_inc, cnt_clr, gcnt_inc, gcnt_clr;

  logic in_load, first_bit, take, mode_eff, load_end;
  logic [GAP_W-1:0] gap_eff;

  assign in_load   = (st_q == ST_IDLE) || (st_q == ST_LOAD);
  assign first_bit = in_load && (cnt == '0);
  assign pat_ready = in_load || ((st_q == ST_LAUNCH) && mode_q);
  assign take      = pat_valid && pat_ready;
  assign mode_eff  = first_bit ? mode_los : mode_q;
  assign gap_eff   = first_bit ? idle_gap : gap_q;
  assign load_end  = mode_eff ? (cnt == END_SHORT) : (cnt == END_FULL);

  sps_counter #(.W(CW)) u_shift_cnt (
    .clk(clk), .rst(rst), .clr(cnt_clr), .inc(cnt_inc), .q(cnt)
  );

  sps_counter #(.W(GAP_W)) u_gap_cnt (
    .clk(clk), .rst(rst), .clr(gcnt_clr), .inc(gcnt_inc), .q(gcnt)
  );

  always_comb begin
    st_n     = st_q;
    iss      = '{ce: 1'b0, se: 1'b1, sin: 1'b0, unl: 1'b0, fin: 1'b0, start: 1'b0};
    cnt_inc  = 1'b0;
    cnt_clr  = 1'b0;
    gcnt_inc = 1'b0;
    gcnt_clr = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_LOAD: begin
        if (take) begin
          iss.ce    = 1'b1;
          iss.sin   = pat_data;
          iss.unl   = unl_q;
          iss.start = (st_q == ST_IDLE);
          if (load_end) begin
            cnt_clr = 1'b1;
            if (mode_eff || (gap_eff == '0)) begin
              st_n = ST_LAUNCH;
            end else begin
              st_n     = ST_GAP;
              gcnt_clr = 1'b1;
            end
          end else begin
            cnt_inc = 1'b1;
            st_n    = ST_LOAD;
          end
        end
      end
      ST_GAP: begin
        iss.se = 1'b0;
        if (gcnt == gap_q - GAP_W'(1)) st_n = ST_LAUNCH;
        else                           gcnt_inc = 1'b1;
      end
      ST_LAUNCH: begin
        if (mode_q) begin
          if (take) begin
            iss.ce  = 1'b1;
            iss.sin = pat_data;
            iss.unl = unl_q;
            st_n    = ST_CAPT;
          end
        end else begin
          iss.ce = 1'b1;
          iss.se = 1'b0;
          st_n   = ST_CAPT;
        end
      end
      ST_CAPT: begin
        iss.ce = 1'b1;
        iss.se = 1'b0;
        st_n   = last_q ? ST_UNLOAD : ST_LOAD;
      end
      ST_UNLOAD: begin
        iss.ce  = 1'b1;
        iss.unl = 1'b1;
        if (cnt == END_FULL) begin
          cnt_clr = 1'b1;
          iss.fin = 1'b1;
          st_n    = ST_IDLE;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      mode_q <= 1'b0;
      gap_q  <= '0;
      last_q <= 1'b0;
      unl_q  <= 1'b0;
    end else begin
      st_q <= st_n;
      if (take && first_bit) begin
        mode_q <= mode_los;
        gap_q  <= idle_gap;
      end
      if (st_q == ST_CAPT) begin
        last_q <= 1'b0;
        unl_q  <= ~last_q;
      end else if (take && pat_last) begin
        last_q <= 1'b1;
      end
    end
  end

  // R7: an unload stage never asks for pattern data
  p_unload_no_ready_r7: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_UNLOAD) |-> !pat_ready);

  // R5: a quiet gap is always left for the launch state
  p_gap_exit_launch_r5: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_GAP && st_n != ST_GAP) |=> (st_q == ST_LAUNCH));
endmodule

// File: rtl/sps_port.sv
module sps_port
  import sps_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  sps_issue_t iss,
  input  logic       scan_out,
  output logic       scan_en,
  output logic       chain_ce,
  output logic       scan_in,
  output logic       rsp_valid,
  output logic       rsp_data,
  output logic       done
);
  logic tag_unl_q, tag_fin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scan_en   <= 1'b1;
      chain_ce  <= 1'b0;
      scan_in   <= 1'b0;
      tag_unl_q <= 1'b0;
      tag_fin_q <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= 1'b0;
      done      <= 1'b0;
    end else begin
      scan_en   <= iss.se;
      chain_ce  <= iss.ce;
      scan_in   <= iss.sin;
      tag_unl_q <= iss.ce && iss.se && iss.unl;
      tag_fin_q <= iss.fin;
      rsp_valid <= chain_ce && tag_unl_q;
      rsp_data  <= scan_out;
      if (iss.start)      done <= 1'b0;
      else if (tag_fin_q) done <= 1'b1;
    end
  end

  // R8: every response bit comes from a shift in the previous cycle
  p_rsp_from_shift_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(chain_ce && scan_en));
endmodule

// File: rtl/scan_pair_seq.sv
module scan_pair_seq
  import sps_pkg::*;
#(
  parameter int CHAIN_LEN = 32,
  parameter int GAP_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_los,
  input  logic [GAP_W-1:0] idle_gap,
  input  logic             pat_valid,
  input  logic             pat_data,
  input  logic             pat_last,
  output logic             pat_ready,
  output logic             scan_en,
  output logic             chain_ce,
  output logic             scan_in,
  input  logic             scan_out,
  output logic             rsp_valid,
  output logic             rsp_data,
  output logic             done
);
  sps_issue_t iss;

  sps_ctrl #(.CHAIN_LEN(CHAIN_LEN), .GAP_W(GAP_W)) u_ctrl (
    .clk(clk), .rst(rst), .mode_los(mode_los), .idle_gap(idle_gap),
    .pat_valid(pat_valid), .pat_data(pat_data), .pat_last(pat_last),
    .pat_ready(pat_ready), .iss(iss)
  );

  sps_port u_port (
    .clk(clk), .rst(rst), .iss(iss), .scan_out(scan_out),
    .scan_en(scan_en), .chain_ce(chain_ce), .scan_in(scan_in),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .done(done)
  );

  // R1: outputs at their reset levels right after reset
  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (scan_en && !chain_ce && !done && !rsp_valid));

  // R6: at most two functional clocks back to back
  p_func_run_max_r6: assert property (@(posedge clk) disable iff (rst)
    (chain_ce && !scan_en && $past(chain_ce && !scan_en)) |=> !(chain_ce && !scan_en));

  // R5: a quiet cycle keeps scan-enable low until launch
  p_gap_leads_launch_r5: assert property (@(posedge clk) disable iff (rst)
    (!chain_ce && !scan_en) |=> !scan_en);

  // R10: chain idle while done is shown
  p_done_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !chain_ce);
endmodule

// File: tb/scan_pair_seq_tb.sv
module scan_pair_seq_tb;
  localparam int L  = 4;
  localparam int GW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_los = 1'b0;
  logic [GW-1:0] idle_gap = '0;
  logic pat_valid = 1'b0, pat_data = 1'b0, pat_last = 1'b0;
  logic pat_ready, scan_en, chain_ce, scan_in, scan_out, rsp_valid, rsp_data, done;
  logic [L-1:0] chain = '0;

  always #5 clk = ~clk;

  scan_pair_seq #(.CHAIN_LEN(L), .GAP_W(GW)) u_dut (
    .clk(clk), .rst(rst), .mode_los(mode_los), .idle_gap(idle_gap),
    .pat_valid(pat_valid), .pat_data(pat_data), .pat_last(pat_last),
    .pat_ready(pat_ready), .scan_en(scan_en), .chain_ce(chain_ce),
    .scan_in(scan_in), .scan_out(scan_out), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .done(done)
  );

  function automatic logic [L-1:0] fn(input logic [L-1:0] v);
    return v ^ {v[L-2:0], v[L-1]} ^ L'(1);
  endfunction

  // Mux-D chain model with simple functional logic
  assign scan_out = chain[L-1];
  always @(posedge clk)
    if (chain_ce) chain <= scan_en ? {chain[L-2:0], scan_in} : fn(chain);

  int n_tests = 0, n_fail = 0, cyc = 0;
  logic [L-1:0] pw [64];
  logic [L-1:0] er [64];
  logic         md [64];
  int tcount = 0;
  bit mon_on = 0;
  int n_shift, n_gap, n_run, bad_len, bad_pre, bad_done, nb, rl;
  bit pf, ps, pre_shift;
  logic [L-1:0] rw;

  function automatic void check(input bit ok, input string req, input string what,
                                input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endfunction

  function automatic void summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got %0d cycles expected below 150000", cyc);
      summary();
      $finish;
    end
  end

  // Port monitor
  always @(negedge clk) begin
    if (!rst && mon_on) begin
      bit fnow;
      if (chain_ce && scan_en) n_shift++;
      if (!chain_ce && !scan_en) n_gap++;
      fnow = chain_ce && !scan_en;
      if (fnow) begin
        if (!pf) pre_shift = ps;
        rl++;
      end else if (pf) begin
        if (n_run < 64) begin
          if (rl != (md[n_run] ? 1 : 2)) bad_len++;
          if (md[n_run] && !pre_shift) bad_pre++;
        end
        n_run++;
        rl = 0;
      end
      pf = fnow;
      ps = chain_ce && scan_en;
      if (rsp_valid) begin
        rw = {rw[L-2:0], rsp_data};
        nb++;
        if (nb % L == 0 && nb / L <= 64) begin
          int ix;
          ix = nb / L - 1;
          if (md[ix]) check(rw == er[ix], "R3 R2 R11", "shift-launch response", int'(rw), int'(er[ix]));
          else        check(rw == er[ix], "R4 R2 R11", "functional-launch response", int'(rw), int'(er[ix]));
        end
      end
      if (done && nb != tcount * L) bad_done++;
    end
  end

  task automatic send_bit(input logic b, input logic m, input logic last, input bit hole);
    bit acc;
    if (hole) begin
      @(negedge clk);
      pat_valid = 1'b0;
      @(posedge clk);
    end
    acc = 1'b0;
    while (!acc) begin
      @(negedge clk);
      pat_valid = 1'b1;
      pat_data  = b;
      mode_los  = m;
      pat_last  = last;
      acc       = pat_ready;
      @(posedge clk);
    end
  endtask

  // mpat: 0 all functional launch, 1 all shift launch, 2 alternate
  task automatic run(input int T, input int gap, input bit stall, input int mpat, input bit exh);
    int gsum;
    rst = 1'b1;
    mon_on = 0;
    pat_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(scan_en == 1'b1 && chain_ce == 1'b0 && rsp_valid == 1'b0 && done == 1'b0 && pat_ready == 1'b1,
          "R1", "reset outputs", {scan_en, chain_ce, rsp_valid, done, pat_ready}, 5'b10001);
    gsum = 0;
    for (int t = 0; t < T; t++) begin
      pw[t] = exh ? L'(t) : L'(t * 5 + 3 + gap);
      md[t] = (mpat == 2) ? t[0] : (mpat == 1);
      er[t] = md[t] ? fn(pw[t]) : fn(fn(pw[t]));
      if (!md[t]) gsum += gap;
    end
    tcount = T;
    n_shift = 0; n_gap = 0; n_run = 0; bad_len = 0; bad_pre = 0; bad_done = 0;
    nb = 0; rl = 0; pf = 0; ps = 0; pre_shift = 0; rw = '0;
    idle_gap = GW'(gap);
    rst = 1'b0;
    mon_on = 1;
    @(negedge clk);
    check(scan_en == 1'b1 && chain_ce == 1'b0 && done == 1'b0, "R1", "after release",
          {scan_en, chain_ce, done}, 3'b100);
    for (int t = 0; t < T; t++)
      for (int k = L - 1; k >= 0; k--)
        send_bit(pw[t][k], md[t], (t == T - 1), stall && ((t * L + k) % 3 == 0));
    @(negedge clk);
    pat_valid = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (done) break;
      @(negedge clk);
    end
    @(negedge clk);
    #1;
    check(done == 1'b1, "R10", "done raised", done, 1);
    check(bad_done == 0, "R10", "done before last bit", bad_done, 0);
    check(nb == T * L, "R8", "response bit count", nb, T * L);
    check(n_shift == (T + 1) * L, stall ? "R7 R9" : "R7", "shift cycles", n_shift, (T + 1) * L);
    check(n_gap == gsum, "R5", "quiet cycles", n_gap, gsum);
    check(n_run == T, "R6", "launch/capture groups", n_run, T);
    check(bad_len == 0, "R6 R4", "functional run length", bad_len, 0);
    check(bad_pre == 0, "R3", "capture not right after launch shift", bad_pre, 0);
    mon_on = 0;
  endtask

  initial begin
    run(5, 0, 1'b0, 2, 1'b0);
    run(5, 3, 1'b1, 2, 1'b0);
    run(4, 1, 1'b1, 1, 1'b0);
    run(4, 7, 1'b0, 0, 1'b0);
    run(16, 2, 1'b0, 2, 1'b1);
    run(1, 0, 1'b0, 0, 1'b0);
    run(1, 5, 1'b1, 1, 1'b0);
    summary();
    $finish;
  end
endmodule